// File: doc/BRIEF.md
# Counter-Synchronised Shared-Memory FIFO Channel

This block moves fixed-width tokens from a producer to a consumer through a circular buffer. The buffer sits in the consumer's local memory. The two sides share no lock, semaphore or common register. Each side owns exactly one counter and advances it alone: the producer owns the write counter and the consumer owns the read counter. Each side also keeps a private copy of the other side's counter. That copy is refreshed only by single-word posted writes that travel over an in-order link with a fixed latency.

On an accepted push, the producer posts the token into the buffer slot and advances its own write counter. It announces the new write count later, in a separate counter write, on the first cycle in which no token is being posted. The link keeps order, so a count can never reach the consumer ahead of the data it covers. On an accepted pop, the consumer advances its read counter and immediately posts the new value back to the producer. That write returns the slot to the producer. Both handshake ports are valid/ready. Each ready or valid is computed only from the counters held on that side. Counters are one bit wider than the slot index, so full and empty can be told apart without a spare slot.

Top module: `cnt_fifo_chan`

## Requirements
- R1: After reset, `push_ready` is 1 and `pop_valid` is 0. The channel is empty and can hold DEPTH tokens.
- R2: Every accepted token is delivered on `pop_data` once, in acceptance order, with its value unchanged.
- R3: The channel holds at most DEPTH tokens that have not been popped. With DEPTH tokens outstanding, `push_ready` is 0. Full means the producer's write count and its copy of the read count have equal index bits and a differing top bit.
- R4: A pop into a full channel is seen by the producer only after the read-count write crosses the link. `push_ready` returns to 1 exactly LINK_LAT clock edges after the edge that accepted the pop.
- R5: A single push into an idle, empty channel raises `pop_valid` exactly LINK_LAT+1 edges after the accepting edge. The data write arrives one edge before the count write that publishes it.
- R6: While pushes are accepted on consecutive cycles, publication of the write count is deferred. The consumer sees no new token until the producer has an idle cycle, and the published count then covers every token already sent.
- R7: While `pop_valid` is 1 and `pop_ready` is 0, `pop_valid` stays 1 and `pop_data` does not change.
- R8: The counters wrap freely. A stream of more than twice DEPTH tokens, with gaps and consumer stalls, passes in order and intact.
- R9: A push offered while `push_ready` is 0 is not taken. After draining, no extra token appears, and the value that was offered is never popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides and the link |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Producer offers a token |
| push_ready | output | 1 | Producer side has free space in its local view |
| push_data | input | DW | Token offered by the producer |
| pop_valid | output | 1 | Consumer side holds a published token |
| pop_ready | input | 1 | Consumer takes the token |
| pop_data | output | DW | Oldest published token |

## Verification
The assertions check counter relations on every cycle:
- the producer never sees more than DEPTH tokens outstanding;
- the consumer's copy of the write count never runs ahead of the true write count, and never moves backwards by more than the ring allows;
- the producer's copy of the read count never passes the consumer's own count;
- a stalled pop output holds still.

Some properties are about whole sequences and are shown only by the bench's scenarios:
- the exact cycle at which a token becomes visible, and at which freed space returns;
- the deferral of the count during a burst;
- the rejection of a push into a full buffer;
- the ordering and integrity of a long wrapping stream.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
    // Kind of a single posted write travelling to the consumer side.
    typedef enum logic {
        BEAT_DATA = 1'b0,
        BEAT_CNT  = 1'b1
    } beat_kind_e;
endpackage

// File: rtl/cfc_link.sv
// In-order posted-write link: a fixed pipeline of LAT register stages.
module cfc_link #(
    parameter int W   = 8,
    parameter int LAT = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    input  logic [W-1:0] in_pay,
    output logic         out_vld,
    output logic [W-1:0] out_pay
);
    typedef struct packed {
        logic [LAT-1:0]        vld;
        logic [LAT-1:0][W-1:0] pay;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = LAT - 1; i > 0; i--) begin
            st_d.vld[i] = st_q.vld[i-1];
            st_d.pay[i] = st_q.pay[i-1];
        end
        st_d.vld[0] = in_vld;
        st_d.pay[0] = in_pay;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld = st_q.vld[LAT-1];
    assign out_pay = st_q.pay[LAT-1];
endmodule

// File: rtl/cfc_prod.sv
// Producer side: owns the write count, keeps a copy of the read count.
module cfc_prod
    import cfc_pkg::*;
#(
    parameter  int DW = 16,
    parameter  int AW = 3,
    localparam int CW = AW + 1,
    localparam int PW = 1 + CW + DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_valid,
    output logic          push_ready,
    input  logic [DW-1:0] push_data,
    input  logic          rd_upd_vld,
    input  logic [CW-1:0] rd_upd_cnt,
    output logic          link_vld,
    output logic [PW-1:0] link_pay,
    output logic [CW-1:0] wr_cnt,
    output logic [CW-1:0] rd_copy
);
    typedef struct packed {
        logic [CW-1:0] wr;
        logic [CW-1:0] rdcp;
        logic [CW-1:0] pub;
    } st_t;

    st_t  st_d, st_q;
    logic full;
    logic fire;

    always_comb begin
        st_d       = st_q;
        link_vld   = 1'b0;
        link_pay   = '0;
        full       = (st_q.wr[AW] != st_q.rdcp[AW]) &&
                     (st_q.wr[AW-1:0] == st_q.rdcp[AW-1:0]);
        push_ready = !full;
        fire       = push_valid && !full;
        if (fire) begin
            // Data write first; the count that covers it follows later.
            link_vld = 1'b1;
            link_pay = {BEAT_DATA, st_q.wr, push_data};
            st_d.wr  = st_q.wr + CW'(1);
        end else if (st_q.wr != st_q.pub) begin
            link_vld = 1'b1;
            link_pay = {BEAT_CNT, st_q.wr, {DW{1'b0}}};
            st_d.pub = st_q.wr;
        end
        if (rd_upd_vld) st_d.rdcp = rd_upd_cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_cnt  = st_q.wr;
    assign rd_copy = st_q.rdcp;
endmodule

// File: rtl/cfc_cons.sv
// Consumer side: holds the ring storage, owns the read count,
// keeps a copy of the write count.
module cfc_cons
    import cfc_pkg::*;
#(
    parameter  int DW    = 16,
    parameter  int DEPTH = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1,
    localparam int PW    = 1 + CW + DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          link_vld,
    input  logic [PW-1:0] link_pay,
    output logic          pop_valid,
    input  logic          pop_ready,
    output logic [DW-1:0] pop_data,
    output logic          ret_vld,
    output logic [CW-1:0] ret_cnt,
    output logic [CW-1:0] rd_cnt,
    output logic [CW-1:0] wr_copy
);
    typedef struct packed {
        logic [CW-1:0]             rd;
        logic [CW-1:0]             wrcp;
        logic [DEPTH-1:0][DW-1:0] mem;
    } st_t;

    st_t           st_d, st_q;
    beat_kind_e    kind;
    logic [CW-1:0] beat_cnt;
    logic [DW-1:0] beat_data;

    always_comb begin
        st_d      = st_q;
        kind      = beat_kind_e'(link_pay[PW-1]);
        beat_cnt  = link_pay[DW +: CW];
        beat_data = link_pay[DW-1:0];
        pop_valid = (st_q.rd != st_q.wrcp);
        pop_data  = st_q.mem[st_q.rd[AW-1:0]];
        ret_vld   = 1'b0;
        ret_cnt   = st_q.rd + CW'(1);
        if (pop_valid && pop_ready) begin
            st_d.rd = st_q.rd + CW'(1);
            ret_vld = 1'b1;
        end
        if (link_vld) begin
            if (kind == BEAT_DATA) st_d.mem[beat_cnt[AW-1:0]] = beat_data;
            else                   st_d.wrcp = beat_cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_cnt  = st_q.rd;
    assign wr_copy = st_q.wrcp;
endmodule

// File: rtl/cnt_fifo_chan.sv
module cnt_fifo_chan #(
    parameter int DW       = 16,
    parameter int DEPTH    = 8,
    parameter int LINK_LAT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_valid,
    output logic          push_ready,
    input  logic [DW-1:0] push_data,
    output logic          pop_valid,
    input  logic          pop_ready,
    output logic [DW-1:0] pop_data
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam int PW = 1 + CW + DW;

    logic          fwd_in_vld,  fwd_out_vld;
    logic [PW-1:0] fwd_in_pay,  fwd_out_pay;
    logic          ret_in_vld,  ret_out_vld;
    logic [CW-1:0] ret_in_cnt,  ret_out_cnt;
    logic [CW-1:0] prod_wr, prod_rdcp, cons_rd, cons_wrcp;

    cfc_prod #(.DW(DW), .AW(AW)) u_prod (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (push_valid),
        .push_ready (push_ready),
        .push_data  (push_data),
        .rd_upd_vld (ret_out_vld),
        .rd_upd_cnt (ret_out_cnt),
        .link_vld   (fwd_in_vld),
        .link_pay   (fwd_in_pay),
        .wr_cnt     (prod_wr),
        .rd_copy    (prod_rdcp)
    );

    cfc_link #(.W(PW), .LAT(LINK_LAT)) u_fwd (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (fwd_in_vld),
        .in_pay  (fwd_in_pay),
        .out_vld (fwd_out_vld),
        .out_pay (fwd_out_pay)
    );

    cfc_cons #(.DW(DW), .DEPTH(DEPTH)) u_cons (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_vld  (fwd_out_vld),
        .link_pay  (fwd_out_pay),
        .pop_valid (pop_valid),
        .pop_ready (pop_ready),
        .pop_data  (pop_data),
        .ret_vld   (ret_in_vld),
        .ret_cnt   (ret_in_cnt),
        .rd_cnt    (cons_rd),
        .wr_copy   (cons_wrcp)
    );

    cfc_link #(.W(CW), .LAT(LINK_LAT)) u_ret (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (ret_in_vld),
        .in_pay  (ret_in_cnt),
        .out_vld (ret_out_vld),
        .out_pay (ret_out_cnt)
    );
endmodule

// File: rtl/cfc_chk.sv
module cfc_chk #(
    parameter int DEPTH = 8,
    parameter int CW    = 4,
    parameter int DW    = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pop_valid,
    input logic          pop_ready,
    input logic [DW-1:0] pop_data,
    input logic [CW-1:0] prod_wr,
    input logic [CW-1:0] prod_rdcp,
    input logic [CW-1:0] cons_rd,
    input logic [CW-1:0] cons_wrcp
);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (CW'(prod_wr - prod_rdcp) <= DEPTH_C));

    // R6
    pub_not_ahead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (CW'(prod_wr - cons_wrcp) <= DEPTH_C));

    // R4
    rd_copy_not_ahead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (CW'(cons_rd - prod_rdcp) <= DEPTH_C));

    // R2
    cons_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (CW'(cons_wrcp - cons_rd) <= DEPTH_C));

    // R8
    wr_copy_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (CW'(cons_wrcp - $past(cons_wrcp)) <= DEPTH_C));

    // R7
    pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_valid && !pop_ready) |=> (pop_valid && $stable(pop_data)));
endmodule

bind cnt_fifo_chan cfc_chk #(.DEPTH(DEPTH), .CW(CW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pop_valid (pop_valid),
    .pop_ready (pop_ready),
    .pop_data  (pop_data),
    .prod_wr   (prod_wr),
    .prod_rdcp (prod_rdcp),
    .cons_rd   (cons_rd),
    .cons_wrcp (cons_wrcp)
);

// File: tb/cnt_fifo_chan_bench.sv
`timescale 1ns/1ps
module cnt_fifo_chan_bench;
    localparam int DW    = 16;
    localparam int DEPTH = 8;
    localparam int LAT   = 3;
    localparam int NTBL  = 20;

    // {gap before push [3:0], token [15:0]}
    localparam logic [19:0] TBL [NTBL] = '{
        20'h0_1111, 20'h0_2222, 20'h1_3333, 20'h0_4444, 20'h0_5555,
        20'h0_6666, 20'h3_7777, 20'h0_8888, 20'h0_9999, 20'h0_AAAA,
        20'h2_BBBB, 20'h0_CCCC, 20'h0_DDDD, 20'h0_EEEE, 20'h5_F0F0,
        20'h0_0F0F, 20'h0_1357, 20'h1_2468, 20'h0_ACE1, 20'h0_BDF2
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          push_valid, push_ready, pop_valid, pop_ready;
    logic [DW-1:0] push_data, pop_data;
    int            n_chk = 0;
    int            n_fail = 0;
    logic [DW-1:0] got;

    always #4 clk = ~clk;

    cnt_fifo_chan #(.DW(DW), .DEPTH(DEPTH), .LINK_LAT(LAT)) u_cnt_fifo_chan (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (push_valid),
        .push_ready (push_ready),
        .push_data  (push_data),
        .pop_valid  (pop_valid),
        .pop_ready  (pop_ready),
        .pop_data   (pop_data)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the accepting edge.
    task automatic push_one(input logic [DW-1:0] d);
        logic f;
        push_valid = 1'b1;
        push_data  = d;
        while (1) begin
            f = push_ready;
            @(negedge clk);
            if (f) break;
        end
        push_valid = 1'b0;
    endtask

    task automatic pop_one(output logic [DW-1:0] d);
        logic f;
        pop_ready = 1'b1;
        while (1) begin
            f = pop_valid;
            d = pop_data;
            @(negedge clk);
            if (f) break;
        end
        pop_ready = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        push_valid = 1'b0;
        pop_ready  = 1'b0;
        push_data  = '0;
        rst_n      = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(push_ready == 1'b1, "R1 push_ready", push_ready, 1);
        chk(pop_valid == 1'b0, "R1 pop_valid", pop_valid, 0);

        // R5: isolated push becomes visible LAT+1 edges later
        push_one(16'h1234);
        for (int m = 0; m <= LAT + 1; m++) begin
            chk(pop_valid == (m == LAT + 1), "R5 visibility", pop_valid, (m == LAT + 1));
            if (m < LAT + 1) @(negedge clk);
        end
        pop_one(got);
        chk(got == 16'h1234, "R2 single token", got, 16'h1234);

        // R6: burst defers publication
        repeat (LAT + 2) @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            push_one(16'h0A00 + 16'(i));
            chk(pop_valid == 1'b0, "R6 burst hidden", pop_valid, 0);
        end
        for (int i = 0; i < 6; i++) begin
            pop_one(got);
            chk(got == 16'h0A00 + 16'(i), "R2 burst order", got, 16'h0A00 + 16'(i));
        end

        // R3: fill to DEPTH
        repeat (LAT + 2) @(negedge clk);
        for (int i = 0; i < DEPTH; i++) push_one(16'h0B00 + 16'(i));
        chk(push_ready == 1'b0, "R3 full", push_ready, 0);
        // R9: offered push refused
        push_valid = 1'b1;
        push_data  = 16'hDEAD;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(push_ready == 1'b0, "R9 still full", push_ready, 0);
        end
        push_valid = 1'b0;
        // R4: space returns LAT edges after the pop
        pop_one(got);
        chk(got == 16'h0B00, "R2 full head", got, 16'h0B00);
        for (int m = 0; m <= LAT; m++) begin
            chk(push_ready == (m >= LAT), "R4 space release", push_ready, (m >= LAT));
            if (m < LAT) @(negedge clk);
        end
        for (int i = 1; i < DEPTH; i++) begin
            pop_one(got);
            chk(got == 16'h0B00 + 16'(i), "R9 drain order", got, 16'h0B00 + 16'(i));
        end
        repeat (LAT + 3) @(negedge clk);
        chk(pop_valid == 1'b0, "R9 no extra token", pop_valid, 0);

        // R7: stalled output holds
        push_one(16'h0C0C);
        while (!pop_valid) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            chk(pop_valid && pop_data == 16'h0C0C, "R7 hold", pop_data, 16'h0C0C);
            @(negedge clk);
        end
        pop_one(got);
        chk(got == 16'h0C0C, "R7 taken", got, 16'h0C0C);

        // R8: table stream with gaps and stalls, wraps the counters
        fork
            begin
                for (int i = 0; i < NTBL; i++) begin
                    repeat (int'(TBL[i][19:16])) @(negedge clk);
                    push_one(TBL[i][15:0]);
                end
            end
            begin
                logic [DW-1:0] d;
                for (int i = 0; i < NTBL; i++) begin
                    repeat (i % 3) @(negedge clk);
                    pop_one(d);
                    chk(d == TBL[i][15:0], "R8 stream", d, TBL[i][15:0]);
                end
            end
        join
        repeat (LAT + 3) @(negedge clk);
        chk(pop_valid == 1'b0 && push_ready == 1'b1, "R8 idle after stream",
            {pop_valid, push_ready}, 2'b01);
        finish_run();
    end
endmodule